// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

The block collects per-bit event pulses into six cause groups arranged in two levels. The primary level has four groups: group A, group B for receive completion queues, group C for transmit completion queues and group D for miscellaneous sources. The secondary level has two error groups. Each group latches its events into a cause register, gates them with a mask register, and forms one summary bit that is the OR of its unmasked cause bits. The secondary summaries have no output of their own. They appear as live, level-sensitive bits in primary group D. Group A holds no stored state: its bits are the live summaries of groups B, C and D.

Software reaches every group through a single-cycle register port. It addresses a group by level and group number and picks one of seven register kinds. Mask set and mask clear writes change only the bits written as one, so an unmask stays safe while the hardware auto-masks other bits. A per-group control bit makes a cause read clear the bits it returned.

The output follows a mode input. In wire mode there is one level-sensitive interrupt line. In the two vector modes there is an index of the lowest-numbered pending request, and the consumer acknowledges that request with a take strobe. A take can set the mask bit of the source it acknowledged.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset every mask register reads all ones, every stored cause bit is zero, and the clear-on-read and auto-mask settings are off. In wire mode both `irq_line` and `vec_valid` are low.
- R2: An event pulse sets its cause bit in the next cycle, and the bit stays set until software clears it. When an event and a clear hit the same bit in the same cycle, the event wins.
- R3: Group A bit 0 is the summary of group B, bit 1 the summary of group C and bit 2 the summary of group D. Each summary is the OR of (cause AND NOT mask) of its group. All other group A bits read 0.
- R4: Group D bit 8 is the live summary of secondary group A (level 1, group 0), and bit 9 is the live summary of secondary group B (level 1, group 1). Event inputs on those two bit positions are ignored. Clearing a secondary cause removes the reflected bit.
- R5: Register kinds are encoded as 0 cause, 1 clear, 2 mask, 3 mask-set, 4 mask-clear, 5 auto-mask enable and 6 control. A mask write loads the whole mask. Mask-set sets, and mask-clear clears, only the bits written as 1.
- R6: A write of kind clear clears only the cause bits written as 1.
- R7: Control bit 0 enables clear-on-read for its group. When it is set, a cause read returns the current cause and clears the returned bits one cycle later. The control register reads back its value.
- R8: Level 0 accepts groups 0 to 3, and level 1 accepts groups 0 and 1. Any other access is answered with `reg_err` high and read data 0, and it changes no state.
- R9: In wire mode (`irq_mode` 0 or 3), `irq_line` is the OR of the unmasked group A bits. In either vector mode, `irq_line` is held low.
- R10: In per-group vector mode (`irq_mode` 2), vectors 0, 1 and 2 correspond to the unmasked group A bits 0, 1 and 2. The lowest pending index is presented first.
- R11: In per-queue vector mode (`irq_mode` 1), vector 2 is the unmasked group D summary, and group B bit i uses vector 3+i. Group C bit j uses vector 3+W+j, and the lowest pending index wins.
- R12: When `vec_take` is high while `vec_valid` is high, the mask bit of the taken source is set in the next cycle if its auto-mask enable bit is set. The request then stays down until software writes a mask-clear.
- R13: Every access with `reg_valid` high is answered one cycle later with `reg_ack` high. Read data follows the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_mode | input | 2 | Output mode: 0/3 wire, 1 per-queue vectors, 2 per-group vectors |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 write, 0 read |
| reg_level | input | 1 | 0 primary, 1 secondary |
| reg_group | input | 2 | Group number within the level |
| reg_kind | input | 3 | Register kind (see R5) |
| reg_wdata | input | W | Write data |
| reg_ack | output | 1 | Access answered (one cycle after request) |
| reg_err | output | 1 | Access addressed an invalid level/group |
| reg_rdata | output | W | Read data |
| ev_rxq | input | W | Event pulses into primary group B |
| ev_txq | input | W | Event pulses into primary group C |
| ev_misc | input | W | Event pulses into primary group D |
| ev_tx_err | input | W | Event pulses into secondary group A |
| ev_rx_err | input | W | Event pulses into secondary group B |
| irq_line | output | 1 | Level-sensitive interrupt in wire mode |
| vec_valid | output | 1 | A vector request is pending |
| vec_index | output | $clog2(3+2*W) | Index of the lowest pending vector |
| vec_take | input | 1 | Acknowledge of the presented vector |

## Verification
The bench builds the block with the default group width of 32. At that width the full vector space is reachable: per-queue indices run up to 3+2*32-1, and a transmit-queue bit lands at index 36, above every receive-queue vector. With 32 bits per group, group D's fixed positions (mailboxes 0 to 3, secondary reflections 8 and 9, timer and application events 10 and 11) sit beside free stored bits. This lets the bench check that live and stored bits stay apart within one register. The bench also covers the same-cycle event/clear race, a cascade from a secondary event through group D and group A to the line, and an auto-mask triggered by a take.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [2:0] {
      K_CAUSE = 3'd0,
      K_CLEAR = 3'd1,
      K_MASK  = 3'd2,
      K_MSET  = 3'd3,
      K_MCLR  = 3'd4,
      K_AUTOM = 3'd5,
      K_CTRL  = 3'd6,
      K_RSVD  = 3'd7
   } reg_kind_e;

   typedef enum logic [1:0] {
      M_WIRE     = 2'd0,
      M_PERQ     = 2'd1,
      M_PERGRP   = 2'd2,
      M_WIRE_ALT = 2'd3
   } out_mode_e;

   localparam int NUM_PRI   = 4;
   localparam int NUM_SEC   = 2;
   localparam int NUM_GRP   = NUM_PRI + NUM_SEC;
   // group A summary positions
   localparam int SUM_B_BIT = 0;
   localparam int SUM_C_BIT = 1;
   localparam int SUM_D_BIT = 2;
   // group D positions carrying the secondary summaries
   localparam int SEC_A_BIT = 8;
   localparam int SEC_B_BIT = 9;
   // vector numbering
   localparam int VEC_D     = 2;
   localparam int VEC_Q0    = 3;

   function automatic logic is_vector(input out_mode_e m);
      return (m == M_PERQ) || (m == M_PERGRP);
   endfunction

endpackage

// File: rtl/irqc_group.sv
module irqc_group
   import irqc_pkg::*;
#(
   parameter int           W     = 32,
   parameter logic [W-1:0] STORE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] live_i,
   input  logic         wr_en,
   input  reg_kind_e    kind_i,
   input  logic [W-1:0] wdata_i,
   input  logic         rd_en,
   input  logic [W-1:0] take_i,
   output logic [W-1:0] cause_o,
   output logic [W-1:0] mask_o,
   output logic [W-1:0] automask_o,
   output logic         cor_o,
   output logic         summary_o
);

   if (W < 1) begin : g_bad_width
      $error("irqc_group: W must be positive");
   end

   logic [W-1:0] held_q, held_d;
   logic [W-1:0] mask_q, mask_d;
   logic [W-1:0] am_q;
   logic         cor_q;
   logic [W-1:0] clr_bits;

   assign cause_o    = (held_q & STORE) | (live_i & ~STORE);
   assign mask_o     = mask_q;
   assign automask_o = am_q;
   assign cor_o      = cor_q;
   assign summary_o  = |(cause_o & ~mask_q);

   always_comb begin
      clr_bits = '0;
      if (wr_en && kind_i == K_CLEAR) clr_bits = wdata_i;
      if (rd_en && cor_q)             clr_bits = clr_bits | cause_o;
      held_d = ((held_q & ~clr_bits) | evt_i) & STORE;
   end

   always_comb begin
      mask_d = mask_q;
      if (wr_en) begin
         unique case (kind_i)
            K_MASK:  mask_d = wdata_i;
            K_MSET:  mask_d = mask_q | wdata_i;
            K_MCLR:  mask_d = mask_q & ~wdata_i;
            default: mask_d = mask_q;
         endcase
      end
      mask_d = mask_d | (take_i & am_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         mask_q <= '1;
         am_q   <= '0;
         cor_q  <= 1'b0;
      end else begin
         held_q <= held_d;
         mask_q <= mask_d;
         if (wr_en && kind_i == K_AUTOM) am_q  <= wdata_i;
         if (wr_en && kind_i == K_CTRL)  cor_q <= wdata_i[0];
      end
   end

   AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & STORE) != '0) |=> ((cause_o & $past(evt_i & STORE)) == $past(evt_i & STORE))); // R2
   AST_MCLR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind_i == K_MCLR && take_i == '0)
      |=> ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i)))); // R5
   AST_MSET_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind_i == K_MSET)
      |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R5
   AST_AUTOMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ((take_i & am_q) != '0) |=> ((mask_q & $past(take_i & am_q)) == $past(take_i & am_q))); // R12

endmodule

// File: rtl/irqc_vec_arb.sv
module irqc_vec_arb
   import irqc_pkg::*;
#(
   parameter int W   = 32,
   parameter int NV  = VEC_Q0 + 2 * W,
   parameter int VIW = $clog2(NV)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  out_mode_e      mode_i,
   input  logic [2:0]     grp_pend_i,
   input  logic [W-1:0]   rxq_pend_i,
   input  logic [W-1:0]   txq_pend_i,
   input  logic           take_i,
   output logic           valid_o,
   output logic [VIW-1:0] index_o,
   output logic [2:0]     take_grp_o,
   output logic [W-1:0]   take_rxq_o,
   output logic [W-1:0]   take_txq_o
);

   if (NV != VEC_Q0 + 2 * W) begin : g_bad_nv
      $error("irqc_vec_arb: NV must equal VEC_Q0 + 2*W");
   end

   logic [NV-1:0] pend;
   logic          hit;

   always_comb begin
      pend = '0;
      if (mode_i == M_PERGRP) begin
         pend[2:0] = grp_pend_i;
      end else if (mode_i == M_PERQ) begin
         pend[VEC_D]          = grp_pend_i[SUM_D_BIT];
         pend[VEC_Q0 +: W]    = rxq_pend_i;
         pend[VEC_Q0+W +: W]  = txq_pend_i;
      end
   end

   always_comb begin
      valid_o = 1'b0;
      index_o = '0;
      for (int i = NV - 1; i >= 0; i--) begin
         if (pend[i]) begin
            valid_o = 1'b1;
            index_o = VIW'(i);
         end
      end
   end

   assign hit = take_i && valid_o;

   always_comb begin
      take_grp_o = '0;
      take_rxq_o = '0;
      take_txq_o = '0;
      for (int i = 0; i < 3; i++) begin
         take_grp_o[i] = hit && (index_o == VIW'(i)) &&
                         (mode_i == M_PERGRP || i == VEC_D);
      end
      for (int i = 0; i < W; i++) begin
         take_rxq_o[i] = hit && mode_i == M_PERQ && index_o == VIW'(VEC_Q0 + i);
         take_txq_o[i] = hit && mode_i == M_PERQ && index_o == VIW'(VEC_Q0 + W + i);
      end
   end

   AST_PERGRP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == M_PERGRP && valid_o) |-> (index_o < VIW'(3))); // R10
   AST_PERQ_SKIPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == M_PERQ && valid_o) |-> (index_o >= VIW'(VEC_D))); // R11

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
   import irqc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  irq_mode,
   input  logic                        reg_valid,
   input  logic                        reg_write,
   input  logic                        reg_level,
   input  logic [1:0]                  reg_group,
   input  logic [2:0]                  reg_kind,
   input  logic [W-1:0]                reg_wdata,
   output logic                        reg_ack,
   output logic                        reg_err,
   output logic [W-1:0]                reg_rdata,
   input  logic [W-1:0]                ev_rxq,
   input  logic [W-1:0]                ev_txq,
   input  logic [W-1:0]                ev_misc,
   input  logic [W-1:0]                ev_tx_err,
   input  logic [W-1:0]                ev_rx_err,
   output logic                        irq_line,
   output logic                        vec_valid,
   output logic [$clog2(3+2*W)-1:0]    vec_index,
   input  logic                        vec_take
);

   localparam int           NV      = VEC_Q0 + 2 * W;
   localparam int           VIW     = $clog2(NV);
   localparam logic [W-1:0] STORE_A = '0;
   localparam logic [W-1:0] LIVE_D  = (W'(1) << SEC_A_BIT) | (W'(1) << SEC_B_BIT);
   localparam logic [W-1:0] STORE_D = ~LIVE_D;

   if (W < 12) begin : g_bad_width
      $error("irq_cascade_ctrl: W must be at least 12");
   end

   out_mode_e mode;
   reg_kind_e kind;
   logic      acc_ok;
   logic [2:0] acc_idx;
   logic [NUM_GRP-1:0] sel_wr, sel_rd;

   assign mode    = out_mode_e'(irq_mode);
   assign kind    = reg_kind_e'(reg_kind);
   assign acc_ok  = !reg_level || !reg_group[1];
   assign acc_idx = reg_level ? {2'b10, reg_group[0]} : {1'b0, reg_group};

   always_comb begin
      for (int g = 0; g < NUM_GRP; g++) begin
         sel_wr[g] = reg_valid && reg_write && acc_ok && acc_idx == 3'(g);
         sel_rd[g] = reg_valid && !reg_write && acc_ok && acc_idx == 3'(g) && kind == K_CAUSE;
      end
   end

   logic [W-1:0] cause_g [NUM_GRP];
   logic [W-1:0] mask_g  [NUM_GRP];
   logic [W-1:0] am_g    [NUM_GRP];
   logic         cor_g   [NUM_GRP];
   logic [NUM_SEC-1:0] sum_sec;
   logic [1:0]   sum_bc;
   logic         sum_d, sum_a;
   logic [W-1:0] live_a, live_d;
   logic [2:0]   take_grp;
   logic [W-1:0] take_rxq, take_txq;

   // secondary level: error groups, always level-sensitive, reported via group D
   for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
      irqc_group #(.W(W), .STORE('1)) u_grp (
         .clk(clk), .rst_n(rst_n),
         .evt_i(s == 0 ? ev_tx_err : ev_rx_err), .live_i('0),
         .wr_en(sel_wr[NUM_PRI+s]), .kind_i(kind), .wdata_i(reg_wdata),
         .rd_en(sel_rd[NUM_PRI+s]), .take_i('0),
         .cause_o(cause_g[NUM_PRI+s]), .mask_o(mask_g[NUM_PRI+s]),
         .automask_o(am_g[NUM_PRI+s]), .cor_o(cor_g[NUM_PRI+s]),
         .summary_o(sum_sec[s]));
   end

   // primary queue groups B and C
   for (genvar q = 0; q < 2; q++) begin : g_queue
      irqc_group #(.W(W), .STORE('1)) u_grp (
         .clk(clk), .rst_n(rst_n),
         .evt_i(q == 0 ? ev_rxq : ev_txq), .live_i('0),
         .wr_en(sel_wr[1+q]), .kind_i(kind), .wdata_i(reg_wdata),
         .rd_en(sel_rd[1+q]), .take_i(q == 0 ? take_rxq : take_txq),
         .cause_o(cause_g[1+q]), .mask_o(mask_g[1+q]),
         .automask_o(am_g[1+q]), .cor_o(cor_g[1+q]),
         .summary_o(sum_bc[q]));
   end

   always_comb begin
      live_d            = '0;
      live_d[SEC_A_BIT] = sum_sec[0];
      live_d[SEC_B_BIT] = sum_sec[1];
   end

   irqc_group #(.W(W), .STORE(STORE_D)) u_grp_d (
      .clk(clk), .rst_n(rst_n),
      .evt_i(ev_misc), .live_i(live_d),
      .wr_en(sel_wr[3]), .kind_i(kind), .wdata_i(reg_wdata),
      .rd_en(sel_rd[3]), .take_i('0),
      .cause_o(cause_g[3]), .mask_o(mask_g[3]),
      .automask_o(am_g[3]), .cor_o(cor_g[3]),
      .summary_o(sum_d));

   always_comb begin
      live_a            = '0;
      live_a[SUM_B_BIT] = sum_bc[0];
      live_a[SUM_C_BIT] = sum_bc[1];
      live_a[SUM_D_BIT] = sum_d;
   end

   irqc_group #(.W(W), .STORE(STORE_A)) u_grp_a (
      .clk(clk), .rst_n(rst_n),
      .evt_i('0), .live_i(live_a),
      .wr_en(sel_wr[0]), .kind_i(kind), .wdata_i(reg_wdata),
      .rd_en(sel_rd[0]), .take_i(W'(take_grp)),
      .cause_o(cause_g[0]), .mask_o(mask_g[0]),
      .automask_o(am_g[0]), .cor_o(cor_g[0]),
      .summary_o(sum_a));

   irqc_vec_arb #(.W(W), .NV(NV), .VIW(VIW)) u_arb (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .grp_pend_i(cause_g[0][2:0] & ~mask_g[0][2:0]),
      .rxq_pend_i(cause_g[1] & ~mask_g[1]),
      .txq_pend_i(cause_g[2] & ~mask_g[2]),
      .take_i(vec_take),
      .valid_o(vec_valid), .index_o(vec_index),
      .take_grp_o(take_grp), .take_rxq_o(take_rxq), .take_txq_o(take_txq));

   assign irq_line = sum_a && !is_vector(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_ack   <= 1'b0;
         reg_err   <= 1'b0;
         reg_rdata <= '0;
      end else begin
         reg_ack   <= reg_valid;
         reg_err   <= reg_valid && !acc_ok;
         reg_rdata <= '0;
         if (reg_valid && !reg_write && acc_ok) begin
            for (int g = 0; g < NUM_GRP; g++) begin
               if (acc_idx == 3'(g)) begin
                  unique case (kind)
                     K_CAUSE: reg_rdata <= cause_g[g];
                     K_MASK:  reg_rdata <= mask_g[g];
                     K_AUTOM: reg_rdata <= am_g[g];
                     K_CTRL:  reg_rdata <= W'(cor_g[g]);
                     default: reg_rdata <= '0;
                  endcase
               end
            end
         end
      end
   end

   AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |=> reg_ack); // R13
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_ack && reg_err) |-> (reg_rdata == '0)); // R8
   AST_LINE_QUIET_IN_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      is_vector(mode) |-> !irq_line); // R9
   AST_NO_VEC_IN_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !is_vector(mode) |-> !vec_valid); // R9
   AST_SEC_REFLECT: assert property (@(posedge clk) disable iff (!rst_n)
      cause_g[3][SEC_A_BIT] == sum_sec[0]); // R4

endmodule

// File: tb/tb_irq_cascade_ctrl.sv
module tb_irq_cascade_ctrl;

   localparam int W   = 32;
   localparam int VIW = $clog2(3 + 2 * W);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     irq_mode = 2'd0;
   logic           reg_valid = 1'b0, reg_write = 1'b0, reg_level = 1'b0;
   logic [1:0]     reg_group = '0;
   logic [2:0]     reg_kind = '0;
   logic [W-1:0]   reg_wdata = '0;
   logic           reg_ack, reg_err;
   logic [W-1:0]   reg_rdata;
   logic [W-1:0]   ev_rxq = '0, ev_txq = '0, ev_misc = '0, ev_tx_err = '0, ev_rx_err = '0;
   logic           irq_line, vec_valid;
   logic [VIW-1:0] vec_index;
   logic           vec_take = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   irq_cascade_ctrl #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_level(reg_level),
      .reg_group(reg_group), .reg_kind(reg_kind), .reg_wdata(reg_wdata),
      .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
      .ev_rxq(ev_rxq), .ev_txq(ev_txq), .ev_misc(ev_misc),
      .ev_tx_err(ev_tx_err), .ev_rx_err(ev_rx_err),
      .irq_line(irq_line), .vec_valid(vec_valid), .vec_index(vec_index),
      .vec_take(vec_take));

   typedef struct packed {
      logic [2:0]  ev;    // 0 none,1 rxq,2 txq,3 misc,4 tx_err,5 rx_err
      logic [31:0] evb;
      logic        wr;
      logic        lvl;
      logic [1:0]  grp;
      logic [2:0]  kind;
      logic [31:0] wd;
      logic [31:0] exp;
      logic        xerr;
      logic [3:0]  rq;
   } step_t;

   localparam int NSTEP = 33;
   localparam step_t TBL [NSTEP] = '{
      '{3'd0, 32'h0,   1'b0,1'b0,2'd0,3'd0,32'h0,        32'h0,        1'b0,4'd1},  // R1 A cause
      '{3'd0, 32'h0,   1'b0,1'b0,2'd1,3'd2,32'h0,        32'hFFFFFFFF, 1'b0,4'd1},  // R1 B mask
      '{3'd0, 32'h0,   1'b0,1'b0,2'd2,3'd6,32'h0,        32'h0,        1'b0,4'd1},  // R1 C ctrl
      '{3'd1, 32'h20,  1'b0,1'b0,2'd1,3'd0,32'h0,        32'h20,       1'b0,4'd2},  // R2 latch
      '{3'd0, 32'h0,   1'b0,1'b0,2'd0,3'd0,32'h0,        32'h0,        1'b0,4'd3},  // R3 masked
      '{3'd0, 32'h0,   1'b1,1'b0,2'd1,3'd4,32'h20,       32'h0,        1'b0,4'd5},  // R5 unmask
      '{3'd0, 32'h0,   1'b0,1'b0,2'd0,3'd0,32'h0,        32'h1,        1'b0,4'd3},  // R3 summary B
      '{3'd0, 32'h0,   1'b0,1'b0,2'd1,3'd2,32'h0,        32'hFFFFFFDF, 1'b0,4'd5},  // R5
      '{3'd0, 32'h0,   1'b1,1'b0,2'd1,3'd2,32'hFFFF0000, 32'h0,        1'b0,4'd5},  // R5
      '{3'd0, 32'h0,   1'b1,1'b0,2'd1,3'd3,32'h3,        32'h0,        1'b0,4'd5},  // R5
      '{3'd0, 32'h0,   1'b0,1'b0,2'd1,3'd2,32'h0,        32'hFFFF0003, 1'b0,4'd5},  // R5 set
      '{3'd0, 32'h0,   1'b1,1'b0,2'd1,3'd1,32'h1,        32'h0,        1'b0,4'd6},  // R6
      '{3'd0, 32'h0,   1'b0,1'b0,2'd1,3'd0,32'h0,        32'h20,       1'b0,4'd6},  // R6 kept
      '{3'd0, 32'h0,   1'b1,1'b0,2'd1,3'd1,32'h20,       32'h0,        1'b0,4'd6},  // R6
      '{3'd0, 32'h0,   1'b0,1'b0,2'd1,3'd0,32'h0,        32'h0,        1'b0,4'd6},  // R6 gone
      '{3'd4, 32'h8,   1'b0,1'b1,2'd0,3'd0,32'h0,        32'h8,        1'b0,4'd2},  // R2 sec A
      '{3'd0, 32'h0,   1'b0,1'b0,2'd3,3'd0,32'h0,        32'h0,        1'b0,4'd4},  // R4 masked
      '{3'd0, 32'h0,   1'b1,1'b1,2'd0,3'd4,32'h8,        32'h0,        1'b0,4'd4},  // R4
      '{3'd0, 32'h0,   1'b0,1'b0,2'd3,3'd0,32'h0,        32'h100,      1'b0,4'd4},  // R4 bit 8
      '{3'd0, 32'h0,   1'b0,1'b0,2'd0,3'd0,32'h0,        32'h0,        1'b0,4'd3},  // R3 D masked
      '{3'd0, 32'h0,   1'b1,1'b1,2'd0,3'd1,32'h8,        32'h0,        1'b0,4'd4},  // R4
      '{3'd0, 32'h0,   1'b0,1'b0,2'd3,3'd0,32'h0,        32'h0,        1'b0,4'd4},  // R4 dropped
      '{3'd0, 32'h0,   1'b0,1'b1,2'd2,3'd0,32'h0,        32'h0,        1'b1,4'd8},  // R8 read
      '{3'd0, 32'h0,   1'b1,1'b1,2'd3,3'd2,32'h0,        32'h0,        1'b1,4'd8},  // R8 write
      '{3'd0, 32'h0,   1'b0,1'b1,2'd1,3'd2,32'h0,        32'hFFFFFFFF, 1'b0,4'd8},  // R8 no effect
      '{3'd0, 32'h0,   1'b1,1'b0,2'd2,3'd6,32'h1,        32'h0,        1'b0,4'd7},  // R7
      '{3'd2, 32'h3,   1'b0,1'b0,2'd2,3'd0,32'h0,        32'h3,        1'b0,4'd7},  // R7 read
      '{3'd0, 32'h0,   1'b0,1'b0,2'd2,3'd0,32'h0,        32'h0,        1'b0,4'd7},  // R7 cleared
      '{3'd0, 32'h0,   1'b0,1'b0,2'd2,3'd6,32'h0,        32'h1,        1'b0,4'd7},  // R7 ctrl
      '{3'd0, 32'h0,   1'b1,1'b1,2'd1,3'd4,32'h1,        32'h0,        1'b0,4'd4},  // R4
      '{3'd5, 32'h1,   1'b0,1'b0,2'd3,3'd0,32'h0,        32'h200,      1'b0,4'd4},  // R4 bit 9
      '{3'd3, 32'hD0F, 1'b0,1'b0,2'd3,3'd0,32'h0,        32'hE0F,      1'b0,4'd4},  // R4 ev 8 ignored
      '{3'd0, 32'h0,   1'b0,1'b1,2'd1,3'd0,32'h0,        32'h1,        1'b0,4'd2}   // R2 sec B
   };

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic pulse_ev(input logic [2:0] s, input logic [31:0] b);
      @(negedge clk);
      unique case (s)
         3'd1: ev_rxq = b;
         3'd2: ev_txq = b;
         3'd3: ev_misc = b;
         3'd4: ev_tx_err = b;
         3'd5: ev_rx_err = b;
         default: ;
      endcase
      @(negedge clk);
      ev_rxq = '0; ev_txq = '0; ev_misc = '0; ev_tx_err = '0; ev_rx_err = '0;
   endtask

   task automatic access(input logic wr, input logic lvl, input logic [1:0] grp,
                         input logic [2:0] k, input logic [31:0] wd,
                         output logic [31:0] rd, output logic er);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = wr; reg_level = lvl;
      reg_group = grp; reg_kind = k; reg_wdata = wd;
      @(negedge clk);
      reg_valid = 1'b0;
      check("R13 ack", {31'd0, reg_ack}, 32'd1);
      rd = reg_rdata;
      er = reg_err;
   endtask

   task automatic wreg(input logic lvl, input logic [1:0] grp, input logic [2:0] k,
                       input logic [31:0] wd);
      logic [31:0] rd;
      logic er;
      access(1'b1, lvl, grp, k, wd, rd, er);
   endtask

   task automatic rreg(input logic lvl, input logic [1:0] grp, input logic [2:0] k,
                       output logic [31:0] rd);
      logic er;
      access(1'b0, lvl, grp, k, 32'h0, rd, er);
   endtask

   task automatic check_vec(input string rq, input logic v, input int idx);
      check(rq, {31'd0, vec_valid}, {31'd0, v});
      if (v) check(rq, 32'(vec_index), 32'(idx));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      logic er;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset outputs
      check("R1 irq_line", {31'd0, irq_line}, 32'd0);
      check("R1 vec_valid", {31'd0, vec_valid}, 32'd0);

      for (int i = 0; i < NSTEP; i++) begin
         if (TBL[i].ev != 3'd0) pulse_ev(TBL[i].ev, TBL[i].evb);
         access(TBL[i].wr, TBL[i].lvl, TBL[i].grp, TBL[i].kind, TBL[i].wd, rd, er);
         check($sformatf("R%0d step %0d data", TBL[i].rq, i), rd, TBL[i].exp);
         check($sformatf("R%0d step %0d err", TBL[i].rq, i), {31'd0, er}, {31'd0, TBL[i].xerr});
      end

      // R9 wire mode cascade
      wreg(1'b0, 2'd0, 3'd4, 32'h1);
      check("R9 idle line", {31'd0, irq_line}, 32'd0);
      pulse_ev(3'd1, 32'h20);
      check("R9 line up", {31'd0, irq_line}, 32'd1);
      check("R9 no vector", {31'd0, vec_valid}, 32'd0);

      // R10 per-group vectors
      @(negedge clk); irq_mode = 2'd2;
      @(negedge clk);
      check("R9 line low in vector mode", {31'd0, irq_line}, 32'd0);
      check_vec("R10 B summary", 1'b1, 0);
      wreg(1'b0, 2'd0, 3'd2, 32'h0);
      wreg(1'b0, 2'd3, 3'd4, 32'h200);
      check_vec("R10 lowest first", 1'b1, 0);
      wreg(1'b0, 2'd1, 3'd1, 32'h20);
      check_vec("R10 D summary", 1'b1, 2);

      // R12 auto-mask on take
      pulse_ev(3'd1, 32'h20);
      check_vec("R12 pending", 1'b1, 0);
      wreg(1'b0, 2'd0, 3'd5, 32'h1);
      @(negedge clk); vec_take = 1'b1;
      @(negedge clk); vec_take = 1'b0;
      check_vec("R12 masked after take", 1'b1, 2);
      rreg(1'b0, 2'd0, 3'd2, rd);
      check("R12 mask bit", rd, 32'h1);
      wreg(1'b0, 2'd0, 3'd4, 32'h1);
      check_vec("R12 re-enabled", 1'b1, 0);

      // R11 per-queue vectors
      @(negedge clk); irq_mode = 2'd1;
      @(negedge clk);
      check_vec("R11 D at 2", 1'b1, 2);
      wreg(1'b0, 2'd3, 3'd2, 32'hFFFFFFFF);
      check_vec("R11 rxq 5 at 8", 1'b1, 8);
      wreg(1'b0, 2'd1, 3'd1, 32'h20);
      check_vec("R11 empty", 1'b0, 0);
      pulse_ev(3'd2, 32'h2);
      check_vec("R11 txq masked", 1'b0, 0);
      wreg(1'b0, 2'd2, 3'd4, 32'h2);
      check_vec("R11 txq 1 at 36", 1'b1, 36);

      // R2 event beats a same-cycle clear
      @(negedge clk);
      ev_misc = 32'h1;
      reg_valid = 1'b1; reg_write = 1'b1; reg_level = 1'b0;
      reg_group = 2'd3; reg_kind = 3'd1; reg_wdata = 32'h1;
      @(negedge clk);
      ev_misc = '0; reg_valid = 1'b0;
      rreg(1'b0, 2'd3, 3'd0, rd);
      check("R2 event wins over clear", rd, 32'hE0F);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule